// File: doc/BRIEF.md
# TLB Refill Walker with Permission Check

The walker serves one translation miss at a time, from either the instruction side or the data side. A miss request carries the virtual address, the access kind and the base of the current top-level page directory. The walker reads the directory word and then the page-table entry through a single-word memory port. It tests the entry against the permission flags that the access needs, and writes the entry back with its bookkeeping bits set. It then hands a ready-made pair of translation words to the TLB write logic.

When the directory has no table for the address, or the entry lacks a required flag, the walker does not refill. Instead it raises a slow-path fault that carries the address and a write indication. Software then resolves the miss.

The set of required flags depends on the access kind and on whether the address lies in the kernel region. Kernel flags sit three bit positions above their user counterparts.

Top module: `tlb_walker`

## Requirements
- R1: On accepting a miss, the first memory access is a read at pgd_base + (va >> DIR_SHIFT) * 4.
- R2: If the directory word has all frame bits [31:PAGE_SHIFT] equal to zero, the walk ends in a fault. There is no table read and no memory write.
- R3: Otherwise the entry is read at (dir_word with bits below PAGE_SHIFT cleared) + ((va >> PAGE_SHIFT) & (2^(DIR_SHIFT-PAGE_SHIFT) - 1)) * 4.
- R4: Entry bit layout: present bit 0, execute bit 1, write bit 2, read bit 3, kernel execute/write/read bits 4/5/6, accessed bit 7, dirty bit 8, global bit 9, cacheable bit 10, frame bits [31:13]. Access kinds on miss_kind_i: 0 fetch, 1 load, 2 store, 3 exchange. A fetch requires present, read and execute.
- R5: A load requires read, a store requires write, and an exchange requires both, in each case together with present. For an address at or above KERNEL_BASE, every required flag except present is shifted left by 3 (this applies to fetches too).
- R6: The check passes only if (entry & mask) == mask. A failing check ends in a fault with no memory write. A walk never reports a refill and a fault together.
- R7: On a pass, the entry is written back to the address it was read from, with present and accessed set; a store or an exchange also sets dirty. The refill pulse comes only after this write.
- R8: pd1_o equals the written-back entry masked to frame bits [31:13], cacheable and permission bits 1 to 6.
- R9: pd0_o holds the page address bits [31:13] of va, global in bit 9, a set valid bit in bit 8 and the ASID in bits [7:0].
- R10: A fault is a one-cycle pulse on fault_valid_o with fault_va_o equal to the miss address. fault_write_o is 1 for a store or exchange and 0 for a fetch or load.
- R11: miss_ready_o is high only while no walk is in progress. A request held high during a walk is accepted only after that walk ends.
- R12: After reset, miss_ready_o is high and mem_req_o, refill_valid_o and fault_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request present |
| miss_ready_o | output | 1 | Walker idle, request taken on this edge |
| miss_va_i | input | 32 | Faulting virtual address |
| miss_kind_i | input | 2 | Access kind: fetch, load, store, exchange |
| pgd_base_i | input | 32 | Byte address of the page directory |
| asid_i | input | ASID_W | Current address-space identifier |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Word byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| refill_valid_o | output | 1 | One-cycle pulse: translation words valid |
| pd0_o | output | 32 | Tag word for the TLB write |
| pd1_o | output | 32 | Frame and permission word for the TLB write |
| fault_valid_o | output | 1 | One-cycle pulse: slow-path fault |
| fault_va_o | output | 32 | Address of the faulting access |
| fault_write_o | output | 1 | Fault came from a store or exchange |

## Verification
The bench sweeps all 128 patterns of the low seven entry flags against every access kind in both address regions. A mask built from the wrong flags, or a kernel shift applied to present or skipped for fetches, would flip some outcomes between refill and fault. A wrong directory or table address returns junk read data, so the walk takes the wrong outcome. An empty directory frame with nonzero low bits is also tried. A walker that tested the whole word would go on to read the table. A request held high through a walk shows whether a walker latches a second request early, because the dirty bit in the write-back would then be wrong.

// File: rtl/tlb_walker_pkg.sv
package tlb_walker_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_XCHG  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR, ST_PTE, ST_WB, ST_DONE, ST_FAULT
  } walk_st_e;

  localparam int unsigned ENT_W   = 32;
  localparam int unsigned B_PRES  = 0;
  localparam int unsigned B_EXEC  = 1;
  localparam int unsigned B_WRITE = 2;
  localparam int unsigned B_READ  = 3;
  localparam int unsigned K_SHIFT = 3;
  localparam int unsigned B_ACC   = 7;
  localparam int unsigned B_DIRTY = 8;
  localparam int unsigned B_GLOB  = 9;
  localparam int unsigned B_CACHE = 10;
  localparam int unsigned PD0_VALID = 8;
  localparam int unsigned PD0_GLOB  = 9;
endpackage

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
  import tlb_walker_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned DIR_SHIFT  = 21
) (
  input  logic [ENT_W-1:0] va_i,
  input  logic [ENT_W-1:0] pgd_base_i,
  input  logic [ENT_W-1:0] dir_word_i,
  output logic [ENT_W-1:0] dir_addr_o,
  output logic [ENT_W-1:0] pte_addr_o,
  output logic             dir_present_o
);
  localparam int unsigned  TBL_BITS = DIR_SHIFT - PAGE_SHIFT;
  localparam logic [ENT_W-1:0] PG_MASK  = ~((ENT_W'(1) << PAGE_SHIFT) - ENT_W'(1));
  localparam logic [ENT_W-1:0] IDX_MASK = (ENT_W'(1) << TBL_BITS) - ENT_W'(1);

  logic [ENT_W-1:0] frame;
  logic [ENT_W-1:0] tbl_idx;

  always_comb begin
    dir_addr_o    = pgd_base_i + ((va_i >> DIR_SHIFT) << 2);
    frame         = dir_word_i & PG_MASK;
    tbl_idx       = (va_i >> PAGE_SHIFT) & IDX_MASK;
    pte_addr_o    = frame + (tbl_idx << 2);
    dir_present_o = |frame;
  end
endmodule

// File: rtl/walk_perm_check.sv
module walk_perm_check
  import tlb_walker_pkg::*;
#(
  parameter logic [31:0] KERNEL_BASE = 32'h7000_0000
) (
  input  logic [ENT_W-1:0] va_i,
  input  acc_kind_e        kind_i,
  input  logic [ENT_W-1:0] entry_i,
  output logic             pass_o,
  output logic [ENT_W-1:0] new_entry_o
);
  logic [ENT_W-1:0] user_req;
  logic [ENT_W-1:0] mask;
  logic             kernel;

  always_comb begin
    user_req = '0;
    unique case (kind_i)
      ACC_FETCH: begin
        user_req[B_READ] = 1'b1;
        user_req[B_EXEC] = 1'b1;
      end
      ACC_LOAD:  user_req[B_READ]  = 1'b1;
      ACC_STORE: user_req[B_WRITE] = 1'b1;
      ACC_XCHG: begin
        user_req[B_READ]  = 1'b1;
        user_req[B_WRITE] = 1'b1;
      end
      default: user_req = '0;
    endcase
    kernel = (va_i >= KERNEL_BASE);
    mask   = kernel ? (user_req << K_SHIFT) : user_req;
    mask[B_PRES] = 1'b1;
    pass_o = ((entry_i & mask) == mask);

    new_entry_o = entry_i;
    new_entry_o[B_PRES] = 1'b1;
    new_entry_o[B_ACC]  = 1'b1;
    if (kind_i == ACC_STORE || kind_i == ACC_XCHG) new_entry_o[B_DIRTY] = 1'b1;
  end
endmodule

// File: rtl/walk_pd_pack.sv
module walk_pd_pack
  import tlb_walker_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned ASID_W     = 8
) (
  input  logic [ENT_W-1:0]  va_i,
  input  logic [ENT_W-1:0]  entry_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic [ENT_W-1:0]  pd0_o,
  output logic [ENT_W-1:0]  pd1_o
);
  localparam logic [ENT_W-1:0] PG_MASK   = ~((ENT_W'(1) << PAGE_SHIFT) - ENT_W'(1));
  localparam logic [ENT_W-1:0] PERM_MASK = ENT_W'(32'h7E);
  localparam logic [ENT_W-1:0] PD1_MASK  = PG_MASK | PERM_MASK | (ENT_W'(1) << B_CACHE);

  always_comb begin
    pd1_o = entry_i & PD1_MASK;
    pd0_o = (va_i & PG_MASK) | ENT_W'(asid_i);
    pd0_o[PD0_GLOB]  = entry_i[B_GLOB];
    pd0_o[PD0_VALID] = 1'b1;
  end
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_walker_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT  = 13,
  parameter int unsigned DIR_SHIFT   = 21,
  parameter int unsigned ASID_W      = 8,
  parameter logic [31:0] KERNEL_BASE = 32'h7000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  output logic              miss_ready_o,
  input  logic [31:0]       miss_va_i,
  input  logic [1:0]        miss_kind_i,
  input  logic [31:0]       pgd_base_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              refill_valid_o,
  output logic [31:0]       pd0_o,
  output logic [31:0]       pd1_o,
  output logic              fault_valid_o,
  output logic [31:0]       fault_va_o,
  output logic              fault_write_o
);
  walk_st_e          state_q;
  logic [31:0]       va_q, pgd_q, pte_addr_q, entry_q;
  acc_kind_e         kind_q;
  logic [ASID_W-1:0] asid_q;

  logic [31:0] dir_addr, pte_addr, new_entry;
  logic        dir_present, pass;

  walk_addr_gen #(.PAGE_SHIFT(PAGE_SHIFT), .DIR_SHIFT(DIR_SHIFT)) u_addr (
    .va_i(va_q), .pgd_base_i(pgd_q), .dir_word_i(mem_rdata_i),
    .dir_addr_o(dir_addr), .pte_addr_o(pte_addr), .dir_present_o(dir_present)
  );

  walk_perm_check #(.KERNEL_BASE(KERNEL_BASE)) u_perm (
    .va_i(va_q), .kind_i(kind_q), .entry_i(mem_rdata_i),
    .pass_o(pass), .new_entry_o(new_entry)
  );

  walk_pd_pack #(.PAGE_SHIFT(PAGE_SHIFT), .ASID_W(ASID_W)) u_pack (
    .va_i(va_q), .entry_i(entry_q), .asid_i(asid_q),
    .pd0_o(pd0_o), .pd1_o(pd1_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      pgd_q      <= '0;
      pte_addr_q <= '0;
      entry_q    <= '0;
      kind_q     <= ACC_FETCH;
      asid_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss_valid_i) begin
          va_q    <= miss_va_i;
          kind_q  <= acc_kind_e'(miss_kind_i);
          pgd_q   <= pgd_base_i;
          asid_q  <= asid_i;
          state_q <= ST_DIR;
        end
        ST_DIR: if (mem_ack_i) begin
          pte_addr_q <= pte_addr;
          state_q    <= dir_present ? ST_PTE : ST_FAULT;
        end
        ST_PTE: if (mem_ack_i) begin
          entry_q <= new_entry;
          state_q <= pass ? ST_WB : ST_FAULT;
        end
        ST_WB: if (mem_ack_i) state_q <= ST_DONE;
        ST_DONE, ST_FAULT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    miss_ready_o = (state_q == ST_IDLE);
    mem_req_o    = (state_q == ST_DIR) || (state_q == ST_PTE) || (state_q == ST_WB);
    mem_we_o     = (state_q == ST_WB);
    unique case (state_q)
      ST_DIR:        mem_addr_o = dir_addr;
      ST_PTE, ST_WB: mem_addr_o = pte_addr_q;
      default:       mem_addr_o = '0;
    endcase
    mem_wdata_o    = (state_q == ST_WB) ? entry_q : '0;
    refill_valid_o = (state_q == ST_DONE);
    fault_valid_o  = (state_q == ST_FAULT);
    fault_va_o     = va_q;
    fault_write_o  = (kind_q == ACC_STORE) || (kind_q == ACC_XCHG);
  end
endmodule

// File: rtl/tlb_walker_chk.sv
module tlb_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        miss_ready_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic        mem_ack_i,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        refill_valid_o,
  input logic        fault_valid_o,
  input logic [31:0] pd0_o
);
  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(refill_valid_o && fault_valid_o));

  assert_wb_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[0] && mem_wdata_o[7]));

  assert_refill_after_wb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(refill_valid_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !miss_ready_o);

  assert_fault_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |=> !fault_valid_o);

  assert_pd0_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_valid_o |-> pd0_o[8]);

  assert_addr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

bind tlb_walker tlb_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .miss_ready_o(miss_ready_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_ack_i(mem_ack_i),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .refill_valid_o(refill_valid_o), .fault_valid_o(fault_valid_o), .pd0_o(pd0_o)
);

// File: tb/sim_tlb_walker.sv
module sim_tlb_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_va = '0;
  logic [1:0]  miss_kind = '0;
  logic [31:0] pgd_base = 32'h0010_0000;
  logic [7:0]  asid = 8'h5C;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        refill_valid, fault_valid, fault_write;
  logic [31:0] pd0, pd1, fault_va;

  logic [31:0] exp_dir_addr = '0, exp_pte_addr = '0, dir_word = '0, pte_word = '0;
  int unsigned wr_total = 0, pte_rd_total = 0, cyc = 0;
  logic [31:0] last_wr_addr = '0, last_wr_data = '0;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  tlb_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .miss_valid_i(miss_valid), .miss_ready_o(miss_ready),
    .miss_va_i(miss_va), .miss_kind_i(miss_kind), .pgd_base_i(pgd_base), .asid_i(asid),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .refill_valid_o(refill_valid),
    .pd0_o(pd0), .pd1_o(pd1), .fault_valid_o(fault_valid), .fault_va_o(fault_va),
    .fault_write_o(fault_write)
  );

  // Memory model: only the two expected words exist, anything else reads as junk
  assign mem_ack = mem_req;
  always_comb begin
    if (mem_addr == exp_dir_addr)      mem_rdata = dir_word;
    else if (mem_addr == exp_pte_addr) mem_rdata = pte_word;
    else                               mem_rdata = 32'hDEAD_BEEF;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_we) begin
      wr_total     <= wr_total + 1;
      last_wr_addr <= mem_addr;
      last_wr_data <= mem_wdata;
    end
    if (mem_req && !mem_we && mem_addr == exp_pte_addr && mem_addr != exp_dir_addr)
      pte_rd_total <= pte_rd_total + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] req_mask(input logic [1:0] k, input logic [31:0] va);
    logic [31:0] u;
    case (k)
      2'd0: u = 32'h0A;
      2'd1: u = 32'h08;
      2'd2: u = 32'h04;
      default: u = 32'h0C;
    endcase
    if (va >= 32'h7000_0000) u = u << 3;
    return u | 32'h1;
  endfunction

  // Run one walk and compare outcome against arithmetic expectation
  task automatic walk(input logic [1:0] k, input logic [31:0] va, input logic [31:0] dw,
                      input logic [31:0] pw, input string tag);
    int unsigned w0, r0;
    logic pass, dir_ok;
    logic [31:0] m, ne, e_pd0, e_pd1;
    bit seen;
    @(negedge clk);
    exp_dir_addr = pgd_base + ((va >> 21) << 2);
    exp_pte_addr = (dw & 32'hFFFF_E000) + (((va >> 13) & 32'hFF) << 2);
    dir_word = dw; pte_word = pw;
    miss_va = va; miss_kind = k; miss_valid = 1'b1;
    w0 = wr_total; r0 = pte_rd_total;
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    chk(!miss_ready, {"R11 busy ", tag}, {31'b0, miss_ready}, 32'h0);
    seen = 0;
    for (int n = 0; n < 12 && !seen; n++) begin
      if (refill_valid || fault_valid) seen = 1;
      else @(negedge clk);
    end
    chk(seen, {"R6 walk end ", tag}, 32'(seen), 32'h1);
    dir_ok = |(dw & 32'hFFFF_E000);
    m = req_mask(k, va);
    pass = dir_ok && ((pw & m) == m);
    ne = pw | 32'h81 | ((k >= 2) ? 32'h100 : 32'h0);
    e_pd1 = ne & 32'hFFFF_E47E;
    e_pd0 = (va & 32'hFFFF_E000) | (ne & 32'h200) | 32'h100 | 32'(asid);
    if (!dir_ok) begin
      chk(fault_valid && !refill_valid, {"R2 empty dir faults ", tag}, {30'b0, refill_valid, fault_valid}, 32'h1);
      chk(pte_rd_total == r0 && wr_total == w0, {"R2 no table access ", tag}, pte_rd_total - r0 + wr_total - w0, 32'h0);
    end else if (pass) begin
      chk(refill_valid && !fault_valid, {"R5 R4 refill expected ", tag}, {30'b0, refill_valid, fault_valid}, 32'h2);
      chk(wr_total == w0 + 1 && last_wr_addr == exp_pte_addr, {"R3 writeback addr ", tag}, last_wr_addr, exp_pte_addr);
      chk(last_wr_data == ne, {"R7 writeback data ", tag}, last_wr_data, ne);
      chk(pd1 == e_pd1, {"R8 pd1 ", tag}, pd1, e_pd1);
      chk(pd0 == e_pd0, {"R9 pd0 ", tag}, pd0, e_pd0);
    end else begin
      chk(fault_valid && !refill_valid, {"R6 check fail faults ", tag}, {30'b0, refill_valid, fault_valid}, 32'h1);
      chk(wr_total == w0, {"R6 no writeback ", tag}, wr_total - w0, 32'h0);
    end
    if (fault_valid) begin
      chk(fault_va == va, {"R10 fault va ", tag}, fault_va, va);
      chk(fault_write == k[1], {"R10 write ind ", tag}, 32'(fault_write), 32'(k[1]));
      @(negedge clk);
      chk(!fault_valid, {"R10 pulse ", tag}, 32'(fault_valid), 32'h0);
    end else begin
      @(negedge clk);
    end
    chk(miss_ready, {"R11 idle again ", tag}, 32'(miss_ready), 32'h1);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, pw;
    repeat (3) @(negedge clk);
    chk(miss_ready && !mem_req && !refill_valid && !fault_valid, "R12 reset state",
        {28'b0, miss_ready, mem_req, refill_valid, fault_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready, "R12 ready after reset", 32'(miss_ready), 32'h1);

    // R4 R5 sweep: kinds x regions x low flag patterns
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 2; r++)
        for (int f = 0; f < 128; f++) begin
          va = (r != 0 ? 32'h7000_0000 : 32'h0000_0000) | (32'(f) << 13) | (32'(k) << 21) | 32'h5A4;
          pw = ((32'h100 + 32'(f)) << 13) | 32'(f) | (32'(f[1] ^ f[2]) << 9) | (32'(k & 1) << 10);
          walk(2'(k), va, 32'h00A0_0005 + (32'(k) << 13), pw, "sweep");
        end

    // R2: directory frame zero but low bits set
    for (int k = 0; k < 4; k++)
      walk(2'(k), 32'h0123_4000, 32'h0000_1FFF, 32'hFFFF_FFFF, "empty dir");

    // R11: request held high across a walk, changed after acceptance
    @(negedge clk);
    exp_dir_addr = pgd_base + ((32'h0040_2000 >> 21) << 2);
    dir_word = 32'h00C0_0000;
    exp_pte_addr = 32'h00C0_0000 + (((32'h0040_2000 >> 13) & 32'hFF) << 2);
    pte_word = 32'h0246_000F;
    miss_va = 32'h0040_2000; miss_kind = 2'd1; miss_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    miss_kind = 2'd2;
    for (int n = 0; n < 12 && !refill_valid; n++) @(negedge clk);
    chk(refill_valid && last_wr_data[8] == 1'b0, "R11 first walk uses latched load",
        last_wr_data, 32'h0246_008F);
    @(posedge clk);
    @(negedge clk);
    chk(miss_ready, "R11 ready after first", 32'(miss_ready), 32'h1);
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    for (int n = 0; n < 12 && !refill_valid; n++) @(negedge clk);
    chk(refill_valid && last_wr_data == 32'h0246_018F, "R11 second walk store",
        last_wr_data, 32'h0246_018F);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule